// File: doc/BRIEF.md
# Window Limit Checker with Alert Response

This block watches a stream of 8-bit measurement results, one strobe per result, each tagged with the index of the channel it belongs to. Every channel has its own lower and upper bound, supplied by the register file that owns them. A result that falls outside its window latches a per-channel status flag. The flag stays set until software reads status, and even then it clears only if that channel's most recent measurement is back inside its window.

Unmasked status flags drive a registered, active-low alert line that is meant for an open-drain pin. A bus controller that sees the alert can issue an alert response request. If the request carries the alert response address and the alert is active, the block returns its own 7-bit device address. It then releases the alert until the next status read. After that read, the alert asserts again if any unmasked flag is still set.

Top module: `win_limit_alert`

## Requirements
- R1: While reset is active and on the first cycle after it, `status` is all zero, `alert_n` is 1, `ara_ack` is 0 and `ara_dev` is zero.
- R2: A measurement on channel i sets `status[i]` at the clock edge that samples it, but only when the value is strictly above the upper bound or strictly below the lower bound of channel i. A value equal to either bound is in range.
- R3: With every lower bound at 0x00 and every upper bound at 0xFF, which are the reset values of the bound registers, no measurement value sets any status bit.
- R4: A set status bit stays set on every edge that has no status read.
- R5: On a status read, `status[i]` clears only if the latest measurement on channel i is in range. A measurement in that same cycle counts as the latest. An out-of-range measurement in the same cycle as the read leaves the bit set.
- R6: `alert_n` is a register. It is 0 after an edge exactly when some status bit with its `mask` bit at 0 is set (as updated at that edge) and no alert response is being held.
- R7: A status bit whose `mask` bit is 1 still sets, but it does not pull `alert_n` low.
- R8: An `ara_vld` with `ara_addr` = 7'b0001100 while `alert_n` is 0 raises `ara_ack` for one cycle, with `ara_dev` = DEV_ADDR, at the next edge. At that same edge `alert_n` goes to 1, and it stays at 1 until a status read.
- R9: An alert response request with any other address, or one made while `alert_n` is 1, gives `ara_ack` = 0 and `ara_dev` = 0.
- R10: A measurement whose channel index is NCH or greater changes no status bit.
- R11: A status read ends a held alert response. If an unmasked status bit is still set after that read, `alert_n` returns to 0 at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_vld | input | 1 | Measurement strobe, one cycle per result |
| meas_ch | input | CHW | Channel index of the measurement |
| meas_val | input | DW | Measurement value |
| lo_lim | input | NCH*DW | Lower bounds, channel i at bits [i*DW +: DW] |
| hi_lim | input | NCH*DW | Upper bounds, channel i at bits [i*DW +: DW] |
| mask | input | NCH | Per-channel alert mask, 1 = suppress |
| stat_rd | input | 1 | Status read strobe |
| ara_vld | input | 1 | Alert response request strobe |
| ara_addr | input | 7 | Address carried by the request |
| status | output | NCH | Sticky out-of-window flags |
| alert_n | output | 1 | Registered active-low alert |
| ara_ack | output | 1 | One-cycle reply to a matching request |
| ara_dev | output | 7 | Device address during `ara_ack`, else 0 |

## Verification
The hardest case to reach is a status read that lands in the same cycle as a fresh out-of-range measurement on a channel whose previous value was already back in range. Only the timing decides whether that flag survives. A second hard case is an alert response that is held and then re-armed while masked and unmasked flags are mixed. Directed sequences build both cases on purpose, first bringing a channel out of range, then back in range, then out of range again with the read strobe raised. The random phase then keeps the read and response strobes frequent while bounds, masks and channel indices (including indices past the last channel) are redrawn, so these collisions also happen many times with no planning. Every cycle is compared against a reference model built from the requirements.

// File: rtl/wlc_pkg.sv
package wlc_pkg;

   // Fixed address that every alerting device answers
   localparam logic [6:0] ARA_ADDR = 7'b0001100;

   // State of the alert response handshake
   typedef enum logic {
      RSP_ARMED = 1'b0,
      RSP_HELD  = 1'b1
   } rsp_e;

   function automatic int ch_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/wlc_window.sv
// Per-channel window comparison with a record of the latest verdict
module wlc_window #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hit,
   input  logic [DW-1:0] val,
   input  logic [DW-1:0] lo,
   input  logic [DW-1:0] hi,
   output logic          trip,
   output logic          fault_nx
);

   logic fault_q;
   logic outside;

   // Bounds themselves count as in range
   always_comb outside = (val > hi) || (val < lo);

   assign trip     = hit & outside;
   assign fault_nx = hit ? outside : fault_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fault_q <= 1'b0;
      else        fault_q <= fault_nx;
   end

endmodule

// File: rtl/wlc_sticky.sv
// Sticky flag cleared by a read only once the fault has gone
module wlc_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic trip,
   input  logic fault_nx,
   input  logic rd,
   output logic stat_nx,
   output logic stat_q
);

   always_comb stat_nx = trip | (stat_q & ~(rd & ~fault_nx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= 1'b0;
      else        stat_q <= stat_nx;
   end

endmodule

// File: rtl/wlc_alert.sv
// Registered alert line and the responder for alert response requests
module wlc_alert
   import wlc_pkg::*;
#(
   parameter int         NCH      = 5,
   parameter logic [6:0] DEV_ADDR = 7'h2E
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] stat_nx,
   input  logic [NCH-1:0] mask,
   input  logic           stat_rd,
   input  logic           ara_vld,
   input  logic [6:0]     ara_addr,
   output logic           alert_n,
   output logic           ara_ack,
   output logic [6:0]     ara_dev
);

   rsp_e rsp_q, rsp_nx;
   logic ara_hit;
   logic any_src;

   assign ara_hit = ara_vld && (ara_addr == ARA_ADDR) && !alert_n;
   assign any_src = |(stat_nx & ~mask);

   // A response in the same cycle as a read wins
   always_comb begin
      rsp_nx = rsp_q;
      if (ara_hit)      rsp_nx = RSP_HELD;
      else if (stat_rd) rsp_nx = RSP_ARMED;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_q   <= RSP_ARMED;
         alert_n <= 1'b1;
         ara_ack <= 1'b0;
         ara_dev <= '0;
      end else begin
         rsp_q   <= rsp_nx;
         alert_n <= !(any_src && (rsp_nx == RSP_ARMED));
         ara_ack <= ara_hit;
         ara_dev <= ara_hit ? DEV_ADDR : 7'd0;
      end
   end

endmodule

// File: rtl/win_limit_alert.sv
module win_limit_alert
   import wlc_pkg::*;
#(
   parameter int         NCH      = 5,
   parameter int         DW       = 8,
   parameter logic [6:0] DEV_ADDR = 7'h2E,
   localparam int        CHW      = ch_width(NCH),
   localparam int        LW       = NCH * DW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           meas_vld,
   input  logic [CHW-1:0] meas_ch,
   input  logic [DW-1:0]  meas_val,
   input  logic [LW-1:0]  lo_lim,
   input  logic [LW-1:0]  hi_lim,
   input  logic [NCH-1:0] mask,
   input  logic           stat_rd,
   input  logic           ara_vld,
   input  logic [6:0]     ara_addr,
   output logic [NCH-1:0] status,
   output logic           alert_n,
   output logic           ara_ack,
   output logic [6:0]     ara_dev
);

   if (NCH < 1) begin : g_bad_nch
      $error("win_limit_alert: NCH must be at least 1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("win_limit_alert: DW must be at least 1");
   end
   if (DEV_ADDR == ARA_ADDR) begin : g_bad_addr
      $error("win_limit_alert: DEV_ADDR collides with the response address");
   end

   logic [NCH-1:0] hit, trip, fault_nx, stat_nx;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign hit[i] = meas_vld && (meas_ch == CHW'(i));

      wlc_window #(.DW(DW)) u_win (
         .clk      (clk),
         .rst_n    (rst_n),
         .hit      (hit[i]),
         .val      (meas_val),
         .lo       (lo_lim[i*DW +: DW]),
         .hi       (hi_lim[i*DW +: DW]),
         .trip     (trip[i]),
         .fault_nx (fault_nx[i])
      );

      wlc_sticky u_stk (
         .clk      (clk),
         .rst_n    (rst_n),
         .trip     (trip[i]),
         .fault_nx (fault_nx[i]),
         .rd       (stat_rd),
         .stat_nx  (stat_nx[i]),
         .stat_q   (status[i])
      );
   end

   wlc_alert #(.NCH(NCH), .DEV_ADDR(DEV_ADDR)) u_alert (
      .clk      (clk),
      .rst_n    (rst_n),
      .stat_nx  (stat_nx),
      .mask     (mask),
      .stat_rd  (stat_rd),
      .ara_vld  (ara_vld),
      .ara_addr (ara_addr),
      .alert_n  (alert_n),
      .ara_ack  (ara_ack),
      .ara_dev  (ara_dev)
   );

endmodule

// File: rtl/win_limit_alert_chk.sv
module win_limit_alert_chk
   import wlc_pkg::*;
#(
   parameter int         NCH      = 5,
   parameter logic [6:0] DEV_ADDR = 7'h2E,
   localparam int        CHW      = ch_width(NCH)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           meas_vld,
   input logic [CHW-1:0] meas_ch,
   input logic [NCH-1:0] mask,
   input logic           stat_rd,
   input logic           ara_vld,
   input logic [6:0]     ara_addr,
   input logic [NCH-1:0] status,
   input logic           alert_n,
   input logic           ara_ack,
   input logic [6:0]     ara_dev
);

   localparam logic [CHW:0] NCH_W = (CHW + 1)'(NCH);

   // R1
   rst_state_chk: assert property (@(posedge clk)
      !rst_n |-> (status == '0 && alert_n && !ara_ack && ara_dev == 7'd0));

   // R4
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rd |=> ((status & $past(status)) == $past(status)));

   // R6
   alert_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alert_n) |-> (|(status & ~$past(mask))));

   // R8
   ara_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ara_ack |-> (ara_dev == DEV_ADDR && alert_n));

   // R9
   ara_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ara_ack |-> $past(ara_vld && ara_addr == ARA_ADDR && !alert_n));

   // R9
   ara_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ara_ack |-> (ara_dev == 7'd0));

   // R10
   bad_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_vld && ({1'b0, meas_ch} >= NCH_W) && !stat_rd) |=> (status == $past(status)));

endmodule

bind win_limit_alert win_limit_alert_chk #(.NCH(NCH), .DEV_ADDR(DEV_ADDR)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .meas_vld (meas_vld),
   .meas_ch  (meas_ch),
   .mask     (mask),
   .stat_rd  (stat_rd),
   .ara_vld  (ara_vld),
   .ara_addr (ara_addr),
   .status   (status),
   .alert_n  (alert_n),
   .ara_ack  (ara_ack),
   .ara_dev  (ara_dev)
);

// File: tb/sim_win_limit_alert.sv
`timescale 1ns/1ps
module sim_win_limit_alert;

   localparam int         NCH = 5;
   localparam int         DW  = 8;
   localparam int         CHW = 3;
   localparam logic [6:0] DEV = 7'h2E;
   localparam logic [6:0] ARA = 7'b0001100;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              meas_vld = 1'b0;
   logic [CHW-1:0]    meas_ch  = '0;
   logic [DW-1:0]     meas_val = '0;
   logic [NCH*DW-1:0] lo_lim;
   logic [NCH*DW-1:0] hi_lim;
   logic [NCH-1:0]    mask     = '0;
   logic              stat_rd  = 1'b0;
   logic              ara_vld  = 1'b0;
   logic [6:0]        ara_addr = '0;
   logic [NCH-1:0]    status;
   logic              alert_n;
   logic              ara_ack;
   logic [6:0]        ara_dev;

   logic [DW-1:0] lo_a [NCH];
   logic [DW-1:0] hi_a [NCH];

   always #2.5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < NCH; i++) begin
         lo_lim[i*DW +: DW] = lo_a[i];
         hi_lim[i*DW +: DW] = hi_a[i];
      end
   end

   win_limit_alert #(.NCH(NCH), .DW(DW), .DEV_ADDR(DEV)) u0 (
      .clk(clk), .rst_n(rst_n), .meas_vld(meas_vld), .meas_ch(meas_ch),
      .meas_val(meas_val), .lo_lim(lo_lim), .hi_lim(hi_lim), .mask(mask),
      .stat_rd(stat_rd), .ara_vld(ara_vld), .ara_addr(ara_addr),
      .status(status), .alert_n(alert_n), .ara_ack(ara_ack), .ara_dev(ara_dev)
   );

   // Reference state derived from the requirements
   logic [NCH-1:0] m_stat, m_fault;
   logic           m_rsp, m_alert_n, m_ack;
   logic [6:0]     m_dev;

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all(string tag);
      check(tag, "status",  int'(status),  int'(m_stat));
      check(tag, "alert_n", int'(alert_n), int'(m_alert_n));
      check(tag, "ara_ack", int'(ara_ack), int'(m_ack));
      check(tag, "ara_dev", int'(ara_dev), int'(m_dev));
   endtask

   // One clock: predict, advance, compare, drop strobes
   task automatic cyc(string tag);
      logic [NCH-1:0] fd, sd, st;
      logic o, ack, rn;
      int c;
      fd = m_fault;
      st = '0;
      c  = int'(meas_ch);
      if (meas_vld && c < NCH) begin
         o = (meas_val > hi_a[c]) || (meas_val < lo_a[c]);
         fd[c] = o;
         st[c] = o;
      end
      sd  = st | (m_stat & ~({NCH{stat_rd}} & ~fd));
      ack = ara_vld && (ara_addr == ARA) && !m_alert_n;
      rn  = ack ? 1'b1 : (stat_rd ? 1'b0 : m_rsp);
      @(posedge clk);
      #1;
      m_fault   = fd;
      m_stat    = sd;
      m_rsp     = rn;
      m_alert_n = !((|(sd & ~mask)) && !rn);
      m_ack     = ack;
      m_dev     = ack ? DEV : 7'd0;
      compare_all(tag);
      meas_vld = 1'b0;
      stat_rd  = 1'b0;
      ara_vld  = 1'b0;
   endtask

   task automatic put_meas(int ch, int v);
      meas_vld = 1'b1;
      meas_ch  = CHW'(ch);
      meas_val = DW'(v);
   endtask

   task automatic put_ara(logic [6:0] a);
      ara_vld  = 1'b1;
      ara_addr = a;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd24681));
      for (int i = 0; i < NCH; i++) begin
         lo_a[i] = 8'h00;
         hi_a[i] = 8'hFF;
      end
      m_stat = '0; m_fault = '0; m_rsp = 1'b0; m_alert_n = 1'b1; m_ack = 1'b0; m_dev = '0;
      rst_n = 1'b1;
      #1 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      compare_all("R1");
      rst_n = 1'b1;
      cyc("R1");

      // R3: full-scale bounds never flag
      for (int i = 0; i < NCH; i++) begin
         put_meas(i, 8'h00); cyc("R3");
         put_meas(i, 8'hFF); cyc("R3");
      end

      // R2: bounds are inclusive
      lo_a[1] = 8'h40; hi_a[1] = 8'hC0;
      put_meas(1, 8'h40); cyc("R2");
      put_meas(1, 8'hC0); cyc("R2");
      put_meas(1, 8'h3F); cyc("R2");
      check("R2", "status low side", int'(status[1]), 1);
      put_meas(1, 8'h80); stat_rd = 1'b1; cyc("R5");
      put_meas(1, 8'hC1); cyc("R2");
      check("R6", "alert on unmasked", int'(alert_n), 0);

      // R4: held without a read
      repeat (4) cyc("R4");
      put_meas(1, 8'h80); cyc("R4");

      // R5: read while fault present, then clear, then same-cycle collision
      put_meas(1, 8'hC5); cyc("R5");
      stat_rd = 1'b1; cyc("R5");
      check("R5", "kept while faulty", int'(status[1]), 1);
      put_meas(1, 8'h80); cyc("R5");
      stat_rd = 1'b1; cyc("R5");
      check("R5", "cleared when back in range", int'(status[1]), 0);
      put_meas(1, 8'hC1); stat_rd = 1'b1; cyc("R5");
      check("R5", "same-cycle fault survives read", int'(status[1]), 1);
      put_meas(1, 8'h80); cyc("R5");
      stat_rd = 1'b1; cyc("R5");

      // R7: masked source flags but stays quiet
      lo_a[2] = 8'h20;
      mask = 5'b00100;
      put_meas(2, 8'h10); cyc("R7");
      check("R7", "masked alert", int'(alert_n), 1);
      mask = '0; cyc("R6");

      // R9 wrong address, R8 matching response, R11 re-arm
      put_ara(7'h2C); cyc("R9");
      put_ara(ARA); cyc("R8");
      check("R8", "ack", int'(ara_ack), 1);
      repeat (3) cyc("R8");
      stat_rd = 1'b1; cyc("R11");
      check("R11", "alert back", int'(alert_n), 0);
      put_meas(2, 8'h30); cyc("R11");
      stat_rd = 1'b1; cyc("R11");
      put_ara(ARA); cyc("R9");

      // R10: indices past the last channel
      for (int c = NCH; c < 8; c++) begin
         put_meas(c, 8'h00); cyc("R10");
         put_meas(c, 8'hFF); cyc("R10");
      end

      // Random phase
      for (int n = 0; n < 4000; n++) begin
         if (n % 250 == 0) begin
            for (int i = 0; i < NCH; i++) begin
               lo_a[i] = 8'($urandom_range(0, 120));
               hi_a[i] = 8'($urandom_range(130, 255));
            end
         end
         if ($urandom_range(0, 19) == 0) mask = NCH'($urandom_range(0, 31));
         if ($urandom_range(0, 2) != 0) put_meas($urandom_range(0, 7), $urandom_range(0, 255));
         if ($urandom_range(0, 9) == 0) stat_rd = 1'b1;
         if ($urandom_range(0, 14) == 0) put_ara(($urandom_range(0, 4) != 0) ? ARA : 7'h2D);
         cyc("R2_R5_R6_R8_R10");
      end

      summary();
      $finish;
   end

endmodule